// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a byte-wide flash device model with a 17-bit word address. A host drives an asynchronous-style bus: active-low chip select, read strobe and write strobe, an address, a write data byte and a level that says whether the programming supply is present. The block samples the three strobes into its own clock domain through two flops each and detects the strobe edges there. It holds the current command as the state of a machine, decodes single-cycle and two-cycle command sequences, and selects what a read returns: array contents, identifier bytes, verify data, or polling status.

Program and erase work is handed to an internal operation timer that owns a small behavioural byte array standing in for the cells. A program byte or a chip erase takes a fixed number of clock cycles. Erasing is guarded three ways. It must be armed by two identical consecutive writes. Two consecutive FFH writes abandon an armed sequence. A protection flag rejects the plain erase code from reset until a manual byte program has started, or until an erase verify has seen a byte other than FFH. The state names used below are READ, ID, CID, PV, EV, PROG_ARM, APROG_ARM, ERASE_ARM, AERASE_ARM, ABORT1, PROG_BUSY, APROG_BUSY, ERASE_BUSY and AERASE_BUSY.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the machine is in READ, `bus_doe` is 0, and every array byte reads FFH.
- R2: While `vpp_hi` is 0 the machine enters READ at the next clock edge, any running operation stops with the array unchanged, and bus writes have no effect. READ is still the state after `vpp_hi` rises.
- R3: A write is taken when the synchronised write strobe rises while the synchronised chip select is 0 and the synchronised read strobe is 1. The address is captured at the synchronised falling edge of the write strobe under the same condition. A write pulse made while the read strobe is 0 is ignored.
- R4: `bus_doe` equals (chip select low AND read strobe low), as sampled two clock edges earlier. In READ and in the arm and plain busy states, `bus_dout` is the array byte at the low address bits. Command 00H (or FFH from READ, ID, CID, PV or EV) selects READ.
- R5: Command 80H (ID) returns 1CH at address 0 and D9H at address 1. Command 90H (CID) returns 1CH and D0H. Any other address returns 00H in both states.
- R6: 40H, followed by a write of a data byte other than FFH, enters PROG_BUSY. After PROG_CYC cycles the byte is stored at the address captured on that second write, and the state returns to READ. Command C0H (PV) then returns that byte whatever the bus address.
- R7: 10H or 50H, followed by a data byte other than FFH, enters APROG_BUSY. While this state lasts, a read returns the bitwise inverse of the data. Once it completes, a read returns the data from the array.
- R8: 20H written twice in a row erases the whole array to FFH after ERASE_CYC cycles. When the protection flag is clear, a 20H write is ignored and the state is left unchanged.
- R9: The protection flag is clear after reset. It is set when a 40H program starts, or while in EV the verified byte is not FFH, and it stays set. An auto program (10H/50H) does not set it.
- R10: 30H written twice in a row starts an auto erase that ignores the protection flag. While AERASE_BUSY lasts, a read returns 00H, so bit 7 is 0. When it ends the array is all FFH.
- R11: In any arm state, a write of FFH moves to ABORT1 without starting an operation. In ABORT1 a further FFH returns to READ, and any other value is decoded as a fresh command. In ERASE_ARM or AERASE_ARM, a value other than the arming code or FFH returns to READ. The array is unchanged in every one of these cases.
- R12: In the four busy states, writes are ignored until the operation completes, and the machine then enters READ.
- R13: A command code outside the defined set selects READ.
- R14: A0H enters EV and uses the address captured on that write. A read then returns the array byte at that captured address, whatever the current bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| bus_ce_n | input | 1 | Chip select, active low, asynchronous |
| bus_oe_n | input | 1 | Read strobe, active low, asynchronous |
| bus_we_n | input | 1 | Write strobe, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | 8 | Write data / command byte |
| vpp_hi | input | 1 | Programming supply present, synchronous level |
| bus_dout | output | 8 | Read data |
| bus_doe | output | 1 | Read data drive enable |

## Verification
The bench builds the block with ADDR_W=17, ARRAY_AW=4, PROG_CYC=40 and ERASE_CYC=60. With these values a whole-array erase, a polling window and a write attempted during a busy operation all fit in a few dozen cycles. Keeping the full 17-bit address means the identifier compare is still checked against the whole address width. Starting from a freshly reset array, the short array also lets one run show the protection flag staying clear after an auto program, becoming set after an erase verify that sees a programmed byte, and then allowing a plain chip erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_ID,
        ST_CID,
        ST_PV,
        ST_EV,
        ST_PROG_ARM,
        ST_APROG_ARM,
        ST_ERASE_ARM,
        ST_AERASE_ARM,
        ST_ABORT1,
        ST_PROG_BUSY,
        ST_APROG_BUSY,
        ST_ERASE_BUSY,
        ST_AERASE_BUSY
    } fc_state_t;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_PROG,
        OPK_ERASE
    } op_kind_t;

    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_PROG    = 8'h40;
    localparam logic [7:0] OP_PVER    = 8'hC0;
    localparam logic [7:0] OP_APROG_A = 8'h10;
    localparam logic [7:0] OP_APROG_B = 8'h50;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_EVER    = 8'hA0;
    localparam logic [7:0] OP_AERASE  = 8'h30;
    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_ID      = 8'h80;
    localparam logic [7:0] OP_CID     = 8'h90;

    localparam logic [7:0] ID_MFR     = 8'h1C;
    localparam logic [7:0] ID_DEV     = 8'hD9;
    localparam logic [7:0] ID_CDEV    = 8'hD0;
    localparam logic [7:0] ERASED     = 8'hFF;

    function automatic logic fc_is_busy(input fc_state_t s);
        return (s == ST_PROG_BUSY) || (s == ST_APROG_BUSY) ||
               (s == ST_ERASE_BUSY) || (s == ST_AERASE_BUSY);
    endfunction

endpackage

// File: rtl/fc_bus_sync.sv
module fc_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic ce_lo,
    output logic oe_lo,
    output logic wr_fall,
    output logic wr_rise
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] stage [STAGES];
    logic            we_prev;
    logic            we_now;

    assign pins = {ce_n, oe_n, we_n};

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[g] <= '1;
                end else if (g == 0) begin
                    stage[g] <= pins;
                end else begin
                    stage[g] <= stage[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
        end else begin
            we_prev <= we_now;
        end
    end

    assign we_now  = stage[STAGES-1][0];
    assign ce_lo   = ~stage[STAGES-1][2];
    assign oe_lo   = ~stage[STAGES-1][1];
    assign wr_fall = we_prev & ~we_now & ce_lo & ~oe_lo;
    assign wr_rise = ~we_prev & we_now & ce_lo & ~oe_lo;

endmodule

// File: rtl/fc_op_engine.sv
module fc_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 8,
    parameter int PROG_CYC  = 400,
    parameter int ERASE_CYC = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  op_kind_t      kind,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    op_kind_t      cur_kind;
    logic [AW-1:0] cur_addr;
    logic [7:0]    cur_data;

    assign lim     = (cur_kind == OPK_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
    assign done    = busy && (cnt == lim);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cur_kind <= OPK_NONE;
            cur_addr <= '0;
            cur_data <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED;
            end
        end else if (abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= '0;
            cur_kind <= kind;
            cur_addr <= addr;
            cur_data <= data;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                if (cur_kind == OPK_ERASE) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= ERASED;
                    end
                end else begin
                    mem[cur_addr] <= cur_data;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_hi,
    input  logic          wr_fall,
    input  logic          wr_rise,
    input  logic [AW-1:0] addr_lo,
    input  logic [7:0]    din,
    input  logic [7:0]    rd_byte,
    input  logic          eng_done,
    output fc_state_t     state,
    output logic          start_op,
    output op_kind_t      op_kind,
    output logic [AW-1:0] op_addr,
    output logic [AW-1:0] prog_addr,
    output logic [AW-1:0] ver_addr,
    output logic [7:0]    poll_data,
    output logic          erase_ok
);
    fc_state_t     nxt;
    logic [AW-1:0] fall_addr;

    function automatic fc_state_t decode_cmd(input logic [7:0] c,
                                             input fc_state_t cur,
                                             input logic ok);
        fc_state_t r;
        case (c)
            OP_READ, OP_RESET:      r = ST_READ;
            OP_PROG:                r = ST_PROG_ARM;
            OP_PVER:                r = ST_PV;
            OP_APROG_A, OP_APROG_B: r = ST_APROG_ARM;
            OP_ERASE:               r = ok ? ST_ERASE_ARM : cur;
            OP_EVER:                r = ST_EV;
            OP_AERASE:              r = ST_AERASE_ARM;
            OP_ID:                  r = ST_ID;
            OP_CID:                 r = ST_CID;
            default:                r = ST_READ;
        endcase
        return r;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (!vpp_hi) begin
            nxt = ST_READ;
        end else begin
            unique case (state)
                ST_READ, ST_ID, ST_CID, ST_PV, ST_EV: begin
                    if (wr_rise) nxt = decode_cmd(din, state, erase_ok);
                end
                ST_ABORT1: begin
                    if (wr_rise) nxt = (din == OP_RESET) ? ST_READ : decode_cmd(din, state, erase_ok);
                end
                ST_PROG_ARM: begin
                    if (wr_rise) nxt = (din == OP_RESET) ? ST_ABORT1 : ST_PROG_BUSY;
                end
                ST_APROG_ARM: begin
                    if (wr_rise) nxt = (din == OP_RESET) ? ST_ABORT1 : ST_APROG_BUSY;
                end
                ST_ERASE_ARM: begin
                    if (wr_rise) begin
                        if (din == OP_ERASE)      nxt = ST_ERASE_BUSY;
                        else if (din == OP_RESET) nxt = ST_ABORT1;
                        else                      nxt = ST_READ;
                    end
                end
                ST_AERASE_ARM: begin
                    if (wr_rise) begin
                        if (din == OP_AERASE)     nxt = ST_AERASE_BUSY;
                        else if (din == OP_RESET) nxt = ST_ABORT1;
                        else                      nxt = ST_READ;
                    end
                end
                ST_PROG_BUSY, ST_APROG_BUSY, ST_ERASE_BUSY, ST_AERASE_BUSY: begin
                    if (eng_done) nxt = ST_READ;
                end
                default: nxt = ST_READ;
            endcase
        end
    end

    // outputs towards the operation timer
    always_comb begin
        start_op = fc_is_busy(nxt) && !fc_is_busy(state);
        op_kind  = OPK_NONE;
        if (start_op) begin
            op_kind = ((nxt == ST_PROG_BUSY) || (nxt == ST_APROG_BUSY)) ? OPK_PROG : OPK_ERASE;
        end
        op_addr = fall_addr;
    end

    // captured addresses, polling data and erase protection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_addr <= '0;
            prog_addr <= '0;
            ver_addr  <= '0;
            poll_data <= '0;
            erase_ok  <= 1'b0;
        end else begin
            if (wr_fall && !fc_is_busy(state)) begin
                fall_addr <= addr_lo;
            end
            if (start_op && (op_kind == OPK_PROG)) begin
                prog_addr <= fall_addr;
                poll_data <= din;
            end
            if (wr_rise && (nxt == ST_EV)) begin
                ver_addr <= fall_addr;
            end
            if ((start_op && (state == ST_PROG_ARM)) ||
                ((state == ST_EV) && (rd_byte != ERASED))) begin
                erase_ok <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int ARRAY_AW  = 8,
    parameter int PROG_CYC  = 400,
    parameter int ERASE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              vpp_hi,
    output logic [7:0]        bus_dout,
    output logic              bus_doe
);
    logic                ce_lo;
    logic                oe_lo;
    logic                wr_fall;
    logic                wr_rise;
    fc_state_t           state;
    logic                start_op;
    op_kind_t            op_kind;
    logic [ARRAY_AW-1:0] op_addr;
    logic [ARRAY_AW-1:0] prog_addr;
    logic [ARRAY_AW-1:0] ver_addr;
    logic [ARRAY_AW-1:0] rd_addr;
    logic [7:0]          poll_data;
    logic [7:0]          rd_byte;
    logic                erase_ok;
    logic                eng_busy;
    logic                eng_done;

    fc_bus_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (bus_ce_n),
        .oe_n    (bus_oe_n),
        .we_n    (bus_we_n),
        .ce_lo   (ce_lo),
        .oe_lo   (oe_lo),
        .wr_fall (wr_fall),
        .wr_rise (wr_rise)
    );

    fc_cmd_fsm #(.AW(ARRAY_AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpp_hi    (vpp_hi),
        .wr_fall   (wr_fall),
        .wr_rise   (wr_rise),
        .addr_lo   (bus_addr[ARRAY_AW-1:0]),
        .din       (bus_din),
        .rd_byte   (rd_byte),
        .eng_done  (eng_done),
        .state     (state),
        .start_op  (start_op),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .prog_addr (prog_addr),
        .ver_addr  (ver_addr),
        .poll_data (poll_data),
        .erase_ok  (erase_ok)
    );

    fc_op_engine #(
        .AW        (ARRAY_AW),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (!vpp_hi),
        .start   (start_op),
        .kind    (op_kind),
        .addr    (op_addr),
        .data    (bus_din),
        .rd_addr (rd_addr),
        .busy    (eng_busy),
        .done    (eng_done),
        .rd_data (rd_byte)
    );

    always_comb begin
        unique case (state)
            ST_PV:   rd_addr = prog_addr;
            ST_EV:   rd_addr = ver_addr;
            default: rd_addr = bus_addr[ARRAY_AW-1:0];
        endcase
    end

    always_comb begin
        unique case (state)
            ST_ID, ST_CID: begin
                if (bus_addr == ADDR_W'(0))      bus_dout = ID_MFR;
                else if (bus_addr == ADDR_W'(1)) bus_dout = (state == ST_ID) ? ID_DEV : ID_CDEV;
                else                             bus_dout = 8'h00;
            end
            ST_APROG_BUSY:  bus_dout = ~poll_data;
            ST_AERASE_BUSY: bus_dout = 8'h00;
            default:        bus_dout = rd_byte;
        endcase
    end

    assign bus_doe = ce_lo & oe_lo;

endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vpp_hi,
    input fc_state_t  state,
    input logic       erase_ok,
    input logic       start_op,
    input logic       eng_done,
    input logic       bus_doe,
    input logic [7:0] bus_dout
);
    a_r2_vpp_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi |=> (state == ST_READ));

    a_r8_arm_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_ARM) |-> erase_ok);

    a_r9_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        erase_ok |=> erase_ok);

    a_r6_start_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |=> fc_is_busy(state));

    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_is_busy(state) && !eng_done && vpp_hi) |=> (state == $past(state)));

    a_r10_status_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_AERASE_BUSY) && bus_doe) |-> !bus_dout[7]);

endmodule

bind flash_cmd_ctrl fc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vpp_hi   (vpp_hi),
    .state    (state),
    .erase_ok (erase_ok),
    .start_op (start_op),
    .eng_done (eng_done),
    .bus_doe  (bus_doe),
    .bus_dout (bus_dout)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    localparam int ADDR_W = 17;
    localparam int AAW    = 4;
    localparam int PCYC   = 40;
    localparam int ECYC   = 60;
    localparam int NB     = 1 << AAW;

    localparam int MD_RD = 0, MD_ID = 1, MD_CID = 2, MD_PV = 3, MD_EV = 4;
    localparam int MD_ARM_P = 5, MD_ARM_AP = 6, MD_ARM_E = 7, MD_ARM_AE = 8, MD_AB1 = 9;
    localparam int MD_BUSY_P = 10, MD_BUSY_AP = 11, MD_BUSY_E = 12, MD_BUSY_AE = 13;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n, oe_n, we_n, vpp;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        din;
    logic [7:0]        dout;
    logic              doe;

    int total = 0, bad = 0, doe_total = 0, doe_bad = 0, cyc = 0;

    int         md;
    logic [7:0] mm [NB];
    logic       ok;
    int         lp, ver, pa;
    logic [7:0] pd, poll;
    logic       h1, h2;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .ARRAY_AW(AAW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_din(din), .vpp_hi(vpp), .bus_dout(dout), .bus_doe(doe)
    );

    // R4: drive enable follows the strobes two edges late
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 1'b0;
            h2 <= 1'b0;
        end else begin
            h1 <= !ce_n && !oe_n;
            h2 <= h1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            doe_total++;
            if (doe !== h2) begin
                doe_bad++;
                $display("FAIL R4 doe actual=%0b expected=%0b", doe, h2);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL R1 watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total + doe_total + 1, bad + doe_bad + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
        case (md)
            MD_ID:      return (a == 0) ? 8'h1C : (a == 1) ? 8'hD9 : 8'h00;
            MD_CID:     return (a == 0) ? 8'h1C : (a == 1) ? 8'hD0 : 8'h00;
            MD_PV:      return mm[lp];
            MD_EV:      return mm[ver];
            MD_BUSY_AP: return ~poll;
            MD_BUSY_AE: return 8'h00;
            default:    return mm[int'(a[AAW-1:0])];
        endcase
    endfunction

    task automatic model_idle(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        case (d)
            8'h00, 8'hFF: md = MD_RD;
            8'h40:        md = MD_ARM_P;
            8'hC0:        md = MD_PV;
            8'h10, 8'h50: md = MD_ARM_AP;
            8'h20:        if (ok) md = MD_ARM_E;
            8'hA0: begin
                md  = MD_EV;
                ver = int'(a[AAW-1:0]);
                if (mm[ver] != 8'hFF) ok = 1'b1;
            end
            8'h30:        md = MD_ARM_AE;
            8'h80:        md = MD_ID;
            8'h90:        md = MD_CID;
            default:      md = MD_RD;
        endcase
    endtask

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        if (vpp && md < MD_BUSY_P) begin
            case (md)
                MD_ARM_P, MD_ARM_AP: begin
                    if (d == 8'hFF) md = MD_AB1;
                    else begin
                        if (md == MD_ARM_P) ok = 1'b1;
                        pa = int'(a[AAW-1:0]);
                        pd = d;
                        lp = pa;
                        poll = d;
                        md = (md == MD_ARM_P) ? MD_BUSY_P : MD_BUSY_AP;
                    end
                end
                MD_ARM_E:  md = (d == 8'h20) ? MD_BUSY_E  : (d == 8'hFF) ? MD_AB1 : MD_RD;
                MD_ARM_AE: md = (d == 8'h30) ? MD_BUSY_AE : (d == 8'hFF) ? MD_AB1 : MD_RD;
                MD_AB1:    if (d == 8'hFF) md = MD_RD; else model_idle(a, d);
                default:   model_idle(a, d);
            endcase
        end
    endtask

    task automatic model_finish();
        if (md == MD_BUSY_P || md == MD_BUSY_AP) mm[pa] = pd;
        if (md == MD_BUSY_E || md == MD_BUSY_AE) begin
            for (int i = 0; i < NB; i++) mm[i] = 8'hFF;
        end
        md = MD_RD;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = a; we_n = 1'b0;
        repeat (4) @(negedge clk);
        din = d; we_n = 1'b1;
        repeat (4) @(negedge clk);
        model_write(a, d);
    endtask

    task automatic wr_oe_low(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a; we_n = 1'b0;
        repeat (4) @(negedge clk);
        din = d; we_n = 1'b1;
        repeat (4) @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        repeat (4) @(negedge clk);
        chk(tag, dout, exp_read(a));
        oe_n = 1'b1;
    endtask

    task automatic wait_op(input int n);
        repeat (n + 4) @(negedge clk);
        model_finish();
    endtask

    initial begin
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0; vpp = 1'b1; rst_n = 1'b0;
        md = MD_RD; ok = 1'b0; lp = 0; ver = 0; pa = 0; pd = '0; poll = '0;
        for (int i = 0; i < NB; i++) mm[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R1 doe after reset", {7'd0, doe}, 8'h00);
        rd(3, "R1 erased byte after reset");

        ce_n = 1'b0; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 read strobe high disables", {7'd0, doe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 standby disables", {7'd0, doe}, 8'h00);
        oe_n = 1'b1;

        wr_oe_low(0, 8'h80);
        rd(0, "R3 write with read strobe low ignored");

        wr(0, 8'h80);
        rd(0, "R5 id maker");
        rd(1, "R5 id device");
        rd(5, "R5 id other address");
        wr(0, 8'h90);
        rd(0, "R5 common id maker");
        rd(1, "R5 common id device");

        wr(0, 8'h80);
        wr(0, 8'h20);
        rd(0, "R8 erase ignored after reset");
        wr(0, 8'h20);
        rd(0, "R8 second erase ignored");

        wr(0, 8'h50);
        wr(7, 8'h5A);
        rd(7, "R7 data polling inverse");
        wait_op(PCYC);
        rd(7, "R7 auto program result");

        wr(0, 8'h80);
        wr(0, 8'h20);
        rd(0, "R9 auto program leaves erase locked");

        wr(7, 8'hA0);
        rd(3, "R14 erase verify captured address");

        wr(0, 8'h80);
        wr(0, 8'h20);
        rd(0, "R9 verify miss unlocks erase");
        wr(0, 8'h20);
        wait_op(ECYC);
        rd(7, "R8 chip erase");

        wr(0, 8'h40);
        wr(5, 8'h3C);
        wr(0, 8'h00);
        wr(0, 8'h80);
        wait_op(PCYC);
        rd(0, "R12 writes ignored while busy");
        rd(5, "R6 programmed byte");
        wr(0, 8'hC0);
        rd(9, "R6 program verify");

        wr(0, 8'h10);
        wr(6, 8'h81);
        wait_op(PCYC);
        rd(6, "R7 auto program via 10H");

        wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'hFF);
        rd(5, "R11 erase abort keeps array");
        wr(0, 8'h40); wr(0, 8'hFF); wr(0, 8'hFF);
        rd(5, "R11 program abort keeps array");
        rd(4, "R11 program abort wrote nothing");
        wr(0, 8'h30); wr(0, 8'hFF); wr(0, 8'hFF);
        rd(6, "R11 auto erase abort keeps array");
        wr(0, 8'h20); wr(0, 8'h00);
        rd(5, "R11 erase mismatch cancels");
        wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'h80);
        rd(0, "R11 command after single reset");

        wr(0, 8'h30); wr(0, 8'h30);
        rd(5, "R10 auto erase status");
        wait_op(ECYC);
        rd(5, "R10 auto erase result");

        wr(0, 8'h80); wr(0, 8'h55);
        rd(0, "R13 unknown code to read");

        wr(0, 8'h80);
        @(negedge clk); vpp = 1'b0; md = MD_RD;
        rd(0, "R2 supply low forces read");
        wr(0, 8'h80);
        rd(0, "R2 write ignored supply low");
        @(negedge clk); vpp = 1'b1;
        rd(0, "R2 read after supply rise");
        wr(0, 8'h40); wr(2, 8'h12);
        @(negedge clk); vpp = 1'b0; md = MD_RD;
        repeat (PCYC + 8) @(negedge clk);
        vpp = 1'b1;
        rd(2, "R2 supply loss aborts program");

        $display("test done: total=%0d bad=%0d", total + doe_total, bad + doe_bad);
        $finish;
    end

endmodule